// File: doc/BRIEF.md
# USB Host Wrapper Configuration and Interrupt Register Bank

This block is a 32-bit register bank that sits beside a USB host controller and holds its static settings: a four-bit bus filter bypass, five port strap bits, a six-bit frame-length trim, a byte-order select, a coherency select, a bus-master enable and an error-response enable. Each stored field drives an output pin of the same width. A spare 32-bit word is also provided. Software reaches the bank through a zero-wait APB-style slave port. Only whole 32-bit accesses are supported, and data is little-endian. There is no ready signal: every access completes in its access phase.

The bank also gathers two interrupt sources, a host system error and an address decode error, into one level interrupt. The mask cannot be written directly. Software clears mask bits through a write-only enable word and sets them through a write-only disable word. Status bits are set by one-cycle event pulses and cleared by writing ones to them. An access to an unmapped offset reads as zero. If error responses are enabled, such an access also flags a slave error and records an address decode error.

Top module: `usbctl_csr_bank`

## Requirements
- R1: After reset, frame trim (0x38) reads 0x20, bus-master enable (0x48) reads 1, interrupt mask (0x68) reads 0x3, every other register reads 0, and `irq` is low.
- R2: Configuration words are read/write at these offsets: 0x30 bypass [3:0], 0x34 straps [4:0], 0x38 trim [5:0], 0x40 byte order [0], 0x44 coherency [0], 0x48 bus-master [0], 0x60 error-response enable [0]. Bits outside the fields read 0, and the cfg outputs follow the stored fields.
- R3: The spare word at 0x78 stores and returns all 32 bits.
- R4: Interrupt status (0x64, bit 1 host system error, bit 0 address decode error) is write-one-to-clear. A written 0 leaves the bit unchanged.
- R5: A one-cycle high on `ev_host_err` sets status bit 1, and a high on `ev_addr_err` sets bit 0. When a set and a clear of the same bit fall in one cycle, the set wins.
- R6: A bus write to the mask register (0x68) leaves the mask unchanged.
- R7: A write to 0x6C clears the mask bits where the data has ones. A write to 0x70 sets them. Both offsets read back as 0.
- R8: `irq` is high exactly when a status bit is set whose mask bit is clear. It is registered, so it follows a status or mask change one clock later.
- R9: A read of an unmapped offset returns 0. When error responses are disabled, `pslverr` stays low.
- R10: When the error-response enable is 1, an access to an unmapped offset drives `pslverr` high in its access phase and sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the read access phase |
| pslverr | output | 1 | Error response for unmapped offsets |
| ev_host_err | input | 1 | Host system error event pulse |
| ev_addr_err | input | 1 | Address decode error event pulse |
| cfg_filt_bypass | output | 4 | Bus filter bypass |
| cfg_port_strap | output | 5 | Port strap bits |
| cfg_frame_trim | output | 6 | Frame-length trim |
| cfg_big_endian | output | 1 | Byte-order select |
| cfg_coherent | output | 1 | Coherency select |
| cfg_bus_master | output | 1 | Bus-master enable |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches these properties on every cycle: the registered interrupt tracks status and mask with a one-cycle lag, direct mask writes change nothing, the enable word clears mask bits, event pulses set status, a written one clears status, and unmapped accesses return zero data and raise an error when errors are enabled. Some behaviour can only be seen in the bench scenarios: the reset values, how reserved bits are dropped, the spare word's full width, the enable and disable words reading as zero, and a set winning over a clear in the same cycle. The bench reads these back over the bus.

// File: rtl/usbctl_csr_pkg.sv
package usbctl_csr_pkg;
  localparam int NREG   = 12;
  localparam int NSRC   = 2;
  localparam int FILT_W = 4;
  localparam int PORT_W = 5;
  localparam int TRIM_W = 6;

  localparam int IX_FILT  = 0;
  localparam int IX_PORT  = 1;
  localparam int IX_TRIM  = 2;
  localparam int IX_ENDN  = 3;
  localparam int IX_COH   = 4;
  localparam int IX_BME   = 5;
  localparam int IX_RCTL  = 6;
  localparam int IX_ISTAT = 7;
  localparam int IX_IMASK = 8;
  localparam int IX_IEN   = 9;
  localparam int IX_IDIS  = 10;
  localparam int IX_SPARE = 11;

  localparam int SRC_ADDR = 0;
  localparam int SRC_HOST = 1;

  localparam logic [TRIM_W-1:0] TRIM_RST = 6'h20;
  localparam logic              BME_RST  = 1'b1;
  localparam logic [NSRC-1:0]   MASK_RST = '1;

  function automatic logic [7:0] reg_offset(input int ix);
    case (ix)
      IX_FILT:  return 8'h30;
      IX_PORT:  return 8'h34;
      IX_TRIM:  return 8'h38;
      IX_ENDN:  return 8'h40;
      IX_COH:   return 8'h44;
      IX_BME:   return 8'h48;
      IX_RCTL:  return 8'h60;
      IX_ISTAT: return 8'h64;
      IX_IMASK: return 8'h68;
      IX_IEN:   return 8'h6C;
      IX_IDIS:  return 8'h70;
      default:  return 8'h78;
    endcase
  endfunction
endpackage

// File: rtl/usbctl_addr_dec.sv
module usbctl_addr_dec
  import usbctl_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic              hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign sel[g] = (addr == ADDR_W'(reg_offset(g)));
  end
  assign hit = |sel;
endmodule

// File: rtl/usbctl_cfg_regs.sv
module usbctl_cfg_regs
  import usbctl_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NREG-1:0]   sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [FILT_W-1:0] filt,
  output logic [PORT_W-1:0] port,
  output logic [TRIM_W-1:0] trim,
  output logic              endn,
  output logic              coh,
  output logic              bme,
  output logic              err_en,
  output logic [DATA_W-1:0] spare
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt   <= '0;
      port   <= '0;
      trim   <= TRIM_RST;
      endn   <= 1'b0;
      coh    <= 1'b0;
      bme    <= BME_RST;
      err_en <= 1'b0;
      spare  <= '0;
    end else if (wr) begin
      if (sel[IX_FILT])  filt   <= wdata[FILT_W-1:0];
      if (sel[IX_PORT])  port   <= wdata[PORT_W-1:0];
      if (sel[IX_TRIM])  trim   <= wdata[TRIM_W-1:0];
      if (sel[IX_ENDN])  endn   <= wdata[0];
      if (sel[IX_COH])   coh    <= wdata[0];
      if (sel[IX_BME])   bme    <= wdata[0];
      if (sel[IX_RCTL])  err_en <= wdata[0];
      if (sel[IX_SPARE]) spare  <= wdata;
    end
  end
endmodule

// File: rtl/usbctl_irq_group.sv
module usbctl_irq_group
  import usbctl_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stat,
  input  logic            wr_en,
  input  logic            wr_dis,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] set_in,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] mask_nx;

  assign clr = wr_stat ? wdata : '0;

  always_comb begin
    mask_nx = mask;
    if (wr_en)  mask_nx = mask_nx & ~wdata;
    if (wr_dis) mask_nx = mask_nx | wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= MASK_RST;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | set_in;
      mask   <= mask_nx;
      irq    <= |(status & ~mask);
    end
  end
endmodule

// File: rtl/usbctl_csr_bank.sv
module usbctl_csr_bank
  import usbctl_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  input  logic              ev_host_err,
  input  logic              ev_addr_err,
  output logic [FILT_W-1:0] cfg_filt_bypass,
  output logic [PORT_W-1:0] cfg_port_strap,
  output logic [TRIM_W-1:0] cfg_frame_trim,
  output logic              cfg_big_endian,
  output logic              cfg_coherent,
  output logic              cfg_bus_master,
  output logic              irq
);
  logic              acc, wr, rd, addr_hit, err_en, dec_err;
  logic [NREG-1:0]   sel;
  logic [DATA_W-1:0] spare;
  logic [NSRC-1:0]   irq_stat, irq_mask, ev_set;
  logic [DATA_W-1:0] rb [NREG];
  logic [DATA_W-1:0] rmux;

  assign acc = psel & penable;
  assign wr  = acc & pwrite;
  assign rd  = acc & ~pwrite;

  usbctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(paddr), .sel(sel), .hit(addr_hit)
  );

  usbctl_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(pclk), .rst_n(presetn), .wr(wr), .sel(sel), .wdata(pwdata),
    .filt(cfg_filt_bypass), .port(cfg_port_strap), .trim(cfg_frame_trim),
    .endn(cfg_big_endian), .coh(cfg_coherent), .bme(cfg_bus_master),
    .err_en(err_en), .spare(spare)
  );

  assign dec_err = acc & ~addr_hit & err_en;
  assign pslverr = dec_err;

  always_comb begin
    ev_set           = '0;
    ev_set[SRC_HOST] = ev_host_err;
    ev_set[SRC_ADDR] = ev_addr_err | dec_err;
  end

  usbctl_irq_group u_irq (
    .clk(pclk), .rst_n(presetn),
    .wr_stat(wr & sel[IX_ISTAT]), .wr_en(wr & sel[IX_IEN]),
    .wr_dis(wr & sel[IX_IDIS]), .wdata(pwdata[NSRC-1:0]),
    .set_in(ev_set), .status(irq_stat), .mask(irq_mask), .irq(irq)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) rb[i] = '0;
    rb[IX_FILT][FILT_W-1:0] = cfg_filt_bypass;
    rb[IX_PORT][PORT_W-1:0] = cfg_port_strap;
    rb[IX_TRIM][TRIM_W-1:0] = cfg_frame_trim;
    rb[IX_ENDN][0]          = cfg_big_endian;
    rb[IX_COH][0]           = cfg_coherent;
    rb[IX_BME][0]           = cfg_bus_master;
    rb[IX_RCTL][0]          = err_en;
    rb[IX_ISTAT][NSRC-1:0]  = irq_stat;
    rb[IX_IMASK][NSRC-1:0]  = irq_mask;
    rb[IX_SPARE]            = spare;
    rmux = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rmux = rmux | rb[i];
  end

  assign prdata = rd ? rmux : '0;
endmodule

// File: rtl/usbctl_csr_chk.sv
module usbctl_csr_chk
  import usbctl_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr,
  input logic              ev_host_err,
  input logic              ev_addr_err,
  input logic              irq,
  input logic [NSRC-1:0]   irq_stat,
  input logic [NSRC-1:0]   irq_mask,
  input logic              addr_hit,
  input logic              err_en
);
  logic acc_w;
  assign acc_w = psel & penable & pwrite;

  // R8
  irq_lag_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq == $past(|(irq_stat & ~irq_mask)));

  // R6
  mask_ro_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_w && paddr == ADDR_W'(reg_offset(IX_IMASK))) |=> $stable(irq_mask));

  // R7
  mask_en_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_w && paddr == ADDR_W'(reg_offset(IX_IEN)))
      |=> irq_mask == ($past(irq_mask) & ~$past(pwdata[NSRC-1:0])));

  // R5
  host_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    ev_host_err |=> irq_stat[SRC_HOST]);

  // R4
  w1c_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_w && paddr == ADDR_W'(reg_offset(IX_ISTAT)) && pwdata[SRC_ADDR] && !ev_addr_err)
      |=> !irq_stat[SRC_ADDR]);

  // R9
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && !addr_hit) |-> prdata == '0);

  // R10
  slverr_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !addr_hit && err_en) |-> pslverr);
endmodule

bind usbctl_csr_bank usbctl_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .pslverr(pslverr), .ev_host_err(ev_host_err), .ev_addr_err(ev_addr_err),
  .irq(irq), .irq_stat(irq_stat), .irq_mask(irq_mask),
  .addr_hit(addr_hit), .err_en(err_en)
);

// File: tb/sim_usbctl_csr_bank.sv
`timescale 1ns/1ps
module sim_usbctl_csr_bank;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pslverr;
  logic        ev_host_err = 1'b0, ev_addr_err = 1'b0;
  logic [3:0]  cfg_filt_bypass;
  logic [4:0]  cfg_port_strap;
  logic [5:0]  cfg_frame_trim;
  logic        cfg_big_endian, cfg_coherent, cfg_bus_master, irq;

  int checks = 0;
  int errors = 0;

  always #5 pclk = ~pclk;

  usbctl_csr_bank u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pslverr(pslverr), .ev_host_err(ev_host_err), .ev_addr_err(ev_addr_err),
    .cfg_filt_bypass(cfg_filt_bypass), .cfg_port_strap(cfg_port_strap),
    .cfg_frame_trim(cfg_frame_trim), .cfg_big_endian(cfg_big_endian),
    .cfg_coherent(cfg_coherent), .cfg_bus_master(cfg_bus_master), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1 err = pslverr;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 begin d = prdata; err = pslverr; end
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    rd(a, d, e);
    chk(req, d, exp);
  endtask

  task automatic pulse(input bit host, input bit addr_ev);
    @(negedge pclk);
    ev_host_err = host; ev_addr_err = addr_ev;
    @(negedge pclk);
    ev_host_err = 1'b0; ev_addr_err = 1'b0;
  endtask

  task automatic t_reset();
    rchk("R1 trim", 8'h38, 32'h20);
    rchk("R1 bme", 8'h48, 32'h1);
    rchk("R1 mask", 8'h68, 32'h3);
    rchk("R1 filt", 8'h30, 32'h0);
    rchk("R1 status", 8'h64, 32'h0);
    rchk("R1 spare", 8'h78, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 outs", {16'b0, cfg_filt_bypass, cfg_port_strap, cfg_frame_trim, cfg_bus_master},
        {16'b0, 4'h0, 5'h0, 6'h20, 1'b1});
  endtask

  task automatic t_config();
    logic e;
    wr(8'h30, 32'hFFFF_FFFF, e);
    wr(8'h34, 32'hFFFF_FFFF, e);
    wr(8'h38, 32'hFFFF_FFD5, e);
    wr(8'h40, 32'hFFFF_FFFF, e);
    wr(8'h44, 32'h0000_0003, e);
    wr(8'h48, 32'hFFFF_FFFE, e);
    rchk("R2 filt", 8'h30, 32'hF);
    rchk("R2 port", 8'h34, 32'h1F);
    rchk("R2 trim", 8'h38, 32'h15);
    rchk("R2 endian", 8'h40, 32'h1);
    rchk("R2 coh", 8'h44, 32'h1);
    rchk("R2 bme", 8'h48, 32'h0);
    chk("R2 outs", {16'b0, cfg_filt_bypass, cfg_port_strap, cfg_frame_trim, cfg_bus_master},
        {16'b0, 4'hF, 5'h1F, 6'h15, 1'b0});
    chk("R2 flags", {30'b0, cfg_big_endian, cfg_coherent}, 32'h3);
  endtask

  task automatic t_spare();
    logic e;
    wr(8'h78, 32'hA5C3_1E7F, e);
    rchk("R3 spare", 8'h78, 32'hA5C3_1E7F);
  endtask

  task automatic t_mask_ro();
    logic e;
    wr(8'h68, 32'h0, e);
    rchk("R6 mask", 8'h68, 32'h3);
  endtask

  task automatic t_enable_disable();
    logic e;
    pulse(1'b1, 1'b0);
    rchk("R5 host set", 8'h64, 32'h2);
    chk("R8 masked", {31'b0, irq}, 32'h0);
    wr(8'h6C, 32'h2, e);
    chk("R8 lag", {31'b0, irq}, 32'h0);
    @(negedge pclk);
    chk("R8 rise", {31'b0, irq}, 32'h1);
    rchk("R7 mask after en", 8'h68, 32'h1);
    rchk("R7 en reads 0", 8'h6C, 32'h0);
    wr(8'h70, 32'h2, e);
    @(negedge pclk);
    chk("R8 fall", {31'b0, irq}, 32'h0);
    rchk("R7 mask after dis", 8'h68, 32'h3);
    rchk("R7 dis reads 0", 8'h70, 32'h0);
  endtask

  task automatic t_w1c();
    logic e;
    wr(8'h6C, 32'h3, e);
    pulse(1'b0, 1'b1);
    rchk("R5 addr set", 8'h64, 32'h3);
    wr(8'h64, 32'h1, e);
    rchk("R4 clear bit0", 8'h64, 32'h2);
    wr(8'h64, 32'h0, e);
    rchk("R4 zero keeps", 8'h64, 32'h2);
    wr(8'h64, 32'h2, e);
    rchk("R4 clear bit1", 8'h64, 32'h0);
    @(negedge pclk);
    chk("R8 cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_wins();
    pulse(1'b1, 1'b0);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h64; pwdata = 32'h2;
    @(negedge pclk);
    penable = 1'b1; ev_host_err = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; ev_host_err = 1'b0;
    rchk("R5 set wins", 8'h64, 32'h2);
    begin
      logic e;
      wr(8'h64, 32'h3, e);
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic e;
    rd(8'h3C, d, e);
    chk("R9 data", d, 32'h0);
    chk("R9 no err", {31'b0, e}, 32'h0);
    rchk("R9 status", 8'h64, 32'h0);
    wr(8'h60, 32'h1, e);
    rchk("R2 errctl", 8'h60, 32'h1);
    rd(8'h3C, d, e);
    chk("R10 data", d, 32'h0);
    chk("R10 err rd", {31'b0, e}, 32'h1);
    rchk("R10 status", 8'h64, 32'h1);
    wr(8'h50, 32'hFFFF_FFFF, e);
    chk("R10 err wr", {31'b0, e}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_config();
    t_spare();
    t_mask_ro();
    t_enable_disable();
    t_w1c();
    t_set_wins();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule